// File: doc/BRIEF.md
# Prescaled SPI Master Controller

This block is a byte-wide, register-mapped SPI master. A host reaches it through a small synchronous bus with seven byte registers at offsets 0 to 6. Through these registers the host sets the SCK polarity and phase, picks a power-of-two clock divisor, drives four chip-select lines directly, and moves data through a 4-entry transmit FIFO and a 4-entry receive FIFO. Bytes are shifted MSB first, and one byte is received for every byte sent.

The SCK divisor is taken from a 4-bit code. The two low bits of the code are in the control register and the two high bits are in the extended control register. The code-to-divisor mapping is not monotonic. Each chip-select line has two bits: an enable bit that hands the line to software, and a level bit that gives the value driven on it. While its enable bit is clear, a line stays high.

A bus write is taken on the rising clock edge when `bus_wr` is high. Read data is combinational from `bus_addr`. A read strobe at offset 2 pops the receive FIFO.

Top module: `spi_divclk_master`

## Requirements
- R1: The SCK divisor follows code {ext[1:0], ctrl[1:0]}: 0→2, 1→4, 4→8, 2→16, 3→32, 5→64, 6→128, 7→256, 8→512, 9→1024, 10→2048, 11→4096, and 12 to 15→4096. Within a byte, successive SCK edges are divisor/2 system clocks apart.
- R2: When no byte is in flight, SCK rests at the level of ctrl bit 3 (CPOL). This holds between bytes and after the last byte.
- R3: Bytes are shifted MSB first in all four modes. With ctrl bit 2 (CPHA) = 0, MISO is sampled on the leading SCK edge. With CPHA = 1, it is sampled on the trailing edge. MOSI changes on the edge opposite to sampling.
- R4: While ctrl bit 6 (enable) is 0, SCK does not toggle, status bit 4 (busy) stays 0, and queued bytes stay in the transmit FIFO. Clearing the bit stops any byte in flight.
- R5: A write to offset 2 queues a byte in a 4-entry transmit FIFO. A write while that FIFO is full is dropped and sets status bit 6 (write collision). Status bit 3 reads 1 while the FIFO is full, and bit 2 reads 1 while it is empty.
- R6: Each received byte enters a 4-entry receive FIFO. A byte that arrives while this FIFO is full is dropped. Status bit 0 reads 1 while the FIFO is empty, and bit 1 reads 1 while it is full. A read strobe at offset 2 returns the oldest byte and removes it.
- R7: Status bit 7 is set when each byte completes. Writing 1 to status bit 7 or bit 6 clears that flag. If completion and a clearing write land in the same cycle, the flag ends up set.
- R8: For n = 0 to 3, chip-select output n follows bit n+4 of offset 5 when bit n of offset 5 is 1, and is high otherwise. Writing 0 to offset 5 releases all four lines.
- R9: Offsets 0, 3, 4 and 6 read back what was written. Offsets 4 and 6 affect nothing else.
- R10: After reset, all stored registers are 0, the chip selects are high, SCK is low, and status reads 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at offset 2) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Chip-select lines |

## Verification
The completion of a byte sets the done flag. A host write of 1 to that flag clears it. These two events can land on the same clock edge. The bench provokes this by sweeping the cycle of the clearing write, one cycle at a time, across the last SCK edges of a byte at divide-by-4. For each trial it finds the cycle of the final SCK edge from its own monitor of the SCK pin. The flag is judged set exactly when that final edge falls on the write's edge, and cleared in every other trial. The sweep must hit the coincident case at least once.

// File: rtl/spi_divclk_master.sv
module spi_divclk_master #(
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sck,
  output logic       mosi,
  input  logic       miso,
  output logic [3:0] cs_n
);
  localparam int PW = $clog2(FIFO_DEPTH);
  localparam int CW = PW + 1;

  logic [7:0] ctrl_q, ext_q, param_q, csr_q, timing_q;
  logic       done_q, wcol_q;
  logic [7:0] tx_mem [FIFO_DEPTH];
  logic [7:0] rx_mem [FIFO_DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          busy, lvl;
  logic [CNT_W-1:0] cnt;
  logic [3:0]    edge_no;
  logic [7:0]    sh, rsh;
  logic [3:0]    div_log2;

  wire en   = ctrl_q[6];
  wire cpol = ctrl_q[3];
  wire cpha = ctrl_q[2];
  wire [3:0] div_code = {ext_q[1:0], ctrl_q[1:0]};

  always_comb begin
    case (div_code)
      4'd0:    div_log2 = 4'd1;
      4'd1:    div_log2 = 4'd2;
      4'd4:    div_log2 = 4'd3;
      4'd2:    div_log2 = 4'd4;
      4'd3:    div_log2 = 4'd5;
      4'd5:    div_log2 = 4'd6;
      4'd6:    div_log2 = 4'd7;
      4'd7:    div_log2 = 4'd8;
      4'd8:    div_log2 = 4'd9;
      4'd9:    div_log2 = 4'd10;
      4'd10:   div_log2 = 4'd11;
      default: div_log2 = 4'd12;
    endcase
  end

  wire [CNT_W-1:0] half_m1 = (CNT_W'(1) << (div_log2 - 4'd1)) - CNT_W'(1);

  wire tx_full  = tx_cnt == CW'(FIFO_DEPTH);
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == CW'(FIFO_DEPTH);
  wire rx_empty = rx_cnt == '0;

  wire wr_data = bus_wr && bus_addr == 3'd2;
  wire rd_data = bus_rd && bus_addr == 3'd2 && !rx_empty;
  wire tx_push = wr_data && !tx_full;
  wire start   = en && !busy && !tx_empty;
  wire tick    = busy && cnt == half_m1;
  wire last    = tick && edge_no == 4'd15;
  wire rx_push = last && !rx_full;
  wire [7:0] rx_byte = cpha ? {rsh[6:0], miso} : rsh;
  wire [7:0] status  = {done_q, wcol_q, 1'b0, busy, tx_full, tx_empty, rx_full, rx_empty};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; ext_q <= '0; param_q <= '0; csr_q <= '0; timing_q <= '0;
      done_q <= 1'b0; wcol_q <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          3'd0: ctrl_q <= bus_wdata;
          3'd1: begin
            if (bus_wdata[7]) done_q <= 1'b0;
            if (bus_wdata[6]) wcol_q <= 1'b0;
          end
          3'd3: ext_q    <= bus_wdata;
          3'd4: param_q  <= bus_wdata;
          3'd5: csr_q    <= bus_wdata;
          3'd6: timing_q <= bus_wdata;
          default: ;
        endcase
      end
      if (last) done_q <= 1'b1;
      if (wr_data && tx_full) wcol_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) begin
        tx_mem[tx_wp] <= bus_wdata;
        tx_wp <= tx_wp + PW'(1);
      end
      if (start) tx_rp <= tx_rp + PW'(1);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(start);
      if (rx_push) begin
        rx_mem[rx_wp] <= rx_byte;
        rx_wp <= rx_wp + PW'(1);
      end
      if (rd_data) rx_rp <= rx_rp + PW'(1);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rd_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; lvl <= 1'b0; cnt <= '0; edge_no <= '0; sh <= '0; rsh <= '0;
    end else if (!en) begin
      busy <= 1'b0; lvl <= 1'b0; cnt <= '0;
    end else if (start) begin
      busy <= 1'b1; lvl <= 1'b0; cnt <= '0; edge_no <= '0;
      sh <= tx_mem[tx_rp];
    end else if (busy) begin
      if (tick) begin
        cnt     <= '0;
        lvl     <= ~lvl;
        edge_no <= edge_no + 4'd1;
        if (!edge_no[0]) begin
          if (!cpha) rsh <= {rsh[6:0], miso};
          else if (edge_no != 4'd0) sh <= {sh[6:0], 1'b0};
        end else begin
          if (cpha) rsh <= {rsh[6:0], miso};
          else sh <= {sh[6:0], 1'b0};
        end
        if (last) busy <= 1'b0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign sck  = lvl ^ cpol;
  assign mosi = sh[7];

  for (genvar i = 0; i < 4; i++) begin : g_cs
    assign cs_n[i] = csr_q[i] ? csr_q[i+4] : 1'b1;
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = ctrl_q;
      3'd1:    bus_rdata = status;
      3'd2:    bus_rdata = rx_empty ? 8'h00 : rx_mem[rx_rp];
      3'd3:    bus_rdata = ext_q;
      3'd4:    bus_rdata = param_q;
      3'd5:    bus_rdata = csr_q;
      3'd6:    bus_rdata = timing_q;
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/spi_divclk_master_chk.sv
module spi_divclk_master_chk #(
  parameter int FIFO_DEPTH = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [2:0]    bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          sck,
  input logic [3:0]    cs_n,
  input logic          en,
  input logic          cpol,
  input logic          busy,
  input logic          tx_full,
  input logic [CW-1:0] tx_cnt,
  input logic          wcol_q,
  input logic          rx_push,
  input logic          rx_empty,
  input logic          last,
  input logic          done_q
);
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 3'd5 && bus_wdata == 8'h00 |=> cs_n == 4'hF); // R8
  AST_HALT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy && sck == cpol); // R4
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol); // R2
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(FIFO_DEPTH)); // R5
  AST_WCOL_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 3'd2 && tx_full |=> wcol_q); // R5
  AST_RX_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_empty); // R6
  AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done_q); // R7
endmodule

bind spi_divclk_master spi_divclk_master_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .sck(sck), .cs_n(cs_n), .en(en), .cpol(cpol), .busy(busy), .tx_full(tx_full),
  .tx_cnt(tx_cnt), .wcol_q(wcol_q), .rx_push(rx_push), .rx_empty(rx_empty),
  .last(last), .done_q(done_q)
);

// File: tb/spi_divclk_master_tb.sv
module spi_divclk_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, miso;
  logic [3:0] cs_n;

  spi_divclk_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi), .miso(miso),
    .cs_n(cs_n)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] slave_bytes [256];
  logic [7:0] exp_tx [256];
  logic [7:0] got_tx [256];
  logic [7:0] sl_sh = '0, sl_rx = '0;
  logic prev_sck = 1'b0;
  logic mon_on = 1'b0, cpol_m = 1'b0, cpha_m = 1'b0;
  int exp_half = 1, e = 0, nb = 0, last_cyc = 0, last_done_cyc = -1, sp_err = 0;
  logic [7:0] cur_ctrl = '0;

  assign miso = sl_sh[7];

  always @(negedge clk) begin
    if (!mon_on) begin
      prev_sck = sck;
      e = 0;
    end else begin
      if (e == 0) sl_sh = slave_bytes[nb[7:0]];
      if (sck !== prev_sck) begin
        if (e != 0 && cyc - last_cyc != exp_half) sp_err++;
        last_cyc = cyc;
        if (e % 2 == 0) begin
          if (!cpha_m) sl_rx = {sl_rx[6:0], mosi};
          else if (e != 0) sl_sh = {sl_sh[6:0], 1'b0};
        end else begin
          if (cpha_m) sl_rx = {sl_rx[6:0], mosi};
          else sl_sh = {sl_sh[6:0], 1'b0};
        end
        e++;
        if (e == 16) begin
          e = 0;
          got_tx[nb[7:0]] = sl_rx;
          nb++;
          last_done_cyc = cyc;
        end
        prev_sck = sck;
      end
    end
  end

  function automatic int div_of(input logic [3:0] c);
    case (c)
      4'd0: return 2;    4'd1: return 4;    4'd4: return 8;     4'd2: return 16;
      4'd3: return 32;   4'd5: return 64;   4'd6: return 128;   4'd7: return 256;
      4'd8: return 512;  4'd9: return 1024; 4'd10: return 2048; default: return 4096;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic setup(input logic [1:0] mode, input logic [3:0] code);
    mon_on = 1'b0;
    cur_ctrl = {4'b0000, mode[1], mode[0], code[1:0]};
    wr(3'd3, {6'b0, code[3:2]});
    wr(3'd0, cur_ctrl);
    cpol_m = mode[1]; cpha_m = mode[0];
    exp_half = div_of(code) / 2;
    repeat (2) @(negedge clk);
    mon_on = 1'b1;
    @(negedge clk);
  endtask

  task automatic drain(input int base, input int cnt);
    logic [7:0] s, d;
    for (int i = 0; i < cnt; i++) begin
      rd(3'd1, s);
      chk("R6 rx not empty before read", s[0], 0);
      rd(3'd2, d);
      chk("R3 received byte", d, slave_bytes[base+i]);
    end
    rd(3'd1, s);
    chk("R6 rx empty after drain", s[0], 1);
  endtask

  task automatic run(input int n, input logic [3:0] code, input logic [1:0] mode, input bit do_read);
    logic [7:0] s;
    int base, acc, e0;
    setup(mode, code);
    base = nb;
    acc = (n > 4) ? 4 : n;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (i < 4) exp_tx[base+i] = b;
      wr(3'd2, b);
    end
    repeat (40) @(negedge clk);
    #1 chk("R4 sck idle while disabled", sck, cpol_m);
    chk("R4 no byte sent while disabled", nb, base);
    rd(3'd1, s);
    chk("R4 busy clear while disabled", s[4], 0);
    chk("R4 tx holds bytes while disabled", s[2], 0);
    chk("R5 tx full flag", s[3], (n >= 4) ? 1 : 0);
    chk("R5 collision flag", s[6], (n > 4) ? 1 : 0);
    e0 = sp_err;
    wr(3'd0, cur_ctrl | 8'h40);
    wait (nb == base + acc);
    repeat (4) @(negedge clk);
    #1 chk("R2 sck idle after bytes", sck, cpol_m);
    chk($sformatf("R1 edge spacing code %0d", code), sp_err, e0);
    rd(3'd1, s);
    chk("R7 done flag set", s[7], 1);
    chk("R5 tx empty after run", s[2], 1);
    for (int i = 0; i < acc; i++)
      chk("R3 byte seen by slave", got_tx[base+i], exp_tx[base+i]);
    if (do_read) drain(base, acc);
    wr(3'd1, 8'hC0);
    rd(3'd1, s);
    chk("R7 flags cleared by write", s[7:6], 0);
    wr(3'd0, cur_ctrl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    int hits, base, w;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 256; i++) slave_bytes[i] = 8'($urandom);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    #1 chk("R10 cs idle", cs_n, 4'hF);
    chk("R10 sck low", sck, 0);
    rd(3'd1, s); chk("R10 status", s, 8'h05);
    for (int a = 0; a < 7; a++) begin
      if (a == 1 || a == 2) continue;
      rd(3'(a), d); chk("R10 register zero", d, 0);
    end

    wr(3'd4, 8'hA5); wr(3'd6, 8'h3C); wr(3'd3, 8'hF2); wr(3'd0, 8'h35);
    rd(3'd4, d); chk("R9 param readback", d, 8'hA5);
    rd(3'd6, d); chk("R9 timing readback", d, 8'h3C);
    rd(3'd3, d); chk("R9 ext readback", d, 8'hF2);
    rd(3'd0, d); chk("R9 ctrl readback", d, 8'h35);
    rd(3'd1, s); chk("R9 status untouched", s, 8'h05);
    #1 chk("R9 cs untouched", cs_n, 4'hF);
    wr(3'd0, 8'h00); wr(3'd3, 8'h00);

    for (int k = 0; k < 8; k++) begin
      logic [7:0] v;
      logic [3:0] x;
      v = 8'($urandom);
      wr(3'd5, v);
      for (int i = 0; i < 4; i++) x[i] = v[i] ? v[i+4] : 1'b1;
      #1 chk("R8 chip select pattern", cs_n, x);
    end
    wr(3'd5, 8'hFF); #1 chk("R8 all enabled high", cs_n, 4'hF);
    wr(3'd5, 8'h0F); #1 chk("R8 all enabled low", cs_n, 4'h0);
    wr(3'd5, 8'h00); #1 chk("R8 release", cs_n, 4'hF);

    for (int m = 0; m < 4; m++) run(4, 4'd0, 2'(m), 1'b1);
    run(2, 4'd4, 2'd1, 1'b1);
    run(2, 4'd2, 2'd2, 1'b1);
    for (int k = 0; k < 10; k++)
      run(1 + int'($urandom % 4), 4'($urandom % 6), 2'($urandom), 1'b1);
    run(1, 4'd8, 2'd3, 1'b1);
    run(1, 4'd11, 2'd0, 1'b1);
    run(1, 4'd14, 2'd1, 1'b1);

    run(6, 4'd0, 2'd0, 1'b1);

    base = nb;
    run(4, 4'd1, 2'd2, 1'b0);
    rd(3'd1, s); chk("R6 rx full flag", s[1], 1);
    run(2, 4'd1, 2'd2, 1'b0);
    drain(base, 4);

    hits = 0;
    setup(2'd0, 4'd1);
    for (int dly = 20; dly < 44; dly++) begin
      base = nb;
      wr(3'd2, 8'($urandom));
      wr(3'd0, cur_ctrl | 8'h40);
      repeat (dly) @(negedge clk);
      @(negedge clk);
      bus_addr = 3'd1; bus_wdata = 8'h80; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      #1 w = cyc;
      if (last_done_cyc == w) hits++;
      chk($sformatf("R7 done vs clear offset %0d", dly), bus_rdata[7], (last_done_cyc == w) ? 1 : 0);
      wait (nb == base + 1);
      repeat (3) @(negedge clk);
      rd(3'd2, d);
      wr(3'd1, 8'hC0);
      wr(3'd0, cur_ctrl);
    end
    chk("R7 coincident set and clear reached", (hits > 0) ? 1 : 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule